// File: doc/BRIEF.md
# Sync Input Qualifier with Divider Realignment

This block takes an asynchronous external sync input, brings it into the core clock domain and detects either a high level or a chosen edge on it. The detected event is gated by two enables. When it gets through, it restarts a programmable divide-by-N counter, so that the divided output begins a fresh period at a known instant. Several devices that share one sync wire can use this to line up their divided clocks.

Software controls the block through two byte registers. The sync-control register (address 0) holds a master enable in bit 0, a divider-sync enable in bit 1 and a one-shot select in bit 2. The pin-control register (address 1) holds an edge-mode select in bit 1 and a rising-edge select in bit 0. In one-shot mode, hardware clears the divider-sync enable after the first accepted event. Software reads that bit to learn whether the realignment has happened.

Top module: `syncq_top`

## Requirements
- R1: After reset both registers read 0x00 and no sync event reaches the divider.
- R2: Address 0 selects sync control with valid bits [2:0] and address 1 selects pin control with valid bits [1:0]. All other bits read back as 0 whatever was written to them.
- R3: With the master enable (control bit 0) at 0, the sync input has no effect on the divider, even when control bit 1 is 1.
- R4: With the master enable at 1 and the divider-sync enable (control bit 1) at 0, the sync input has no effect on the divider.
- R5: With control bits 0 and 1 at 1 and bit 2 at 0, every detected event realigns the divider. The counter reads 0 after the third rising clock edge that follows the sync input change.
- R6: With control bits 0, 1 and 2 at 1, only the first detected event realigns the divider. Control bit 1 then reads 0, and later events have no effect.
- R7: A write to the sync-control register in the same cycle as the one-shot self-clear takes priority, so the written value of bit 1 is kept.
- R8: With pin-control bit 1 at 0 (level mode), the divider counter is held at 0 for as long as the synchronized input stays high. Pin-control bit 0 has no effect in this mode.
- R9: With pin-control value 0x03 (rising edge), a 0-to-1 transition realigns the divider and a 1-to-0 transition does not.
- R10: With pin-control value 0x02 (falling edge), a 1-to-0 transition realigns the divider and a 0-to-1 transition does not.
- R11: The divider counts 0 to DIV_N-1 and wraps. The divided output is 1 while the count is below ceil(DIV_N/2) and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address (0 = sync control, 1 = pin control) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| sync_in | input | 1 | Asynchronous external sync input |
| div_out | output | 1 | Divided clock output |
| div_count | output | CW = max(1, clog2(DIV_N)) | Current divider phase |

## Verification
Every test first lines up the divider phase to 0, then changes the sync input, and checks the count three edges later. A realigning event gives 0 there and an ignored one gives 3, so the two outcomes cannot be confused. Rising and falling transitions are applied under each edge polarity, which shows that the polarity select actually chooses the edge. Holding the input high in level mode shows a sustained hold rather than a single pulse. Repeating events under one-shot mode, and a write that collides with the self-clear, separate the first accepted event from the later ones.

// File: rtl/syncq_pkg.sv
package syncq_pkg;
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_PIN  = 1'b1;
    localparam logic [7:0] CTRL_MASK = 8'h07;
    localparam logic [7:0] PIN_MASK  = 8'h03;

    typedef struct packed {
        logic one_shot;
        logic div_sync_en;
        logic master_en;
    } ctrl_t;

    typedef struct packed {
        logic edge_mode;
        logic rise_sel;
    } pin_t;
endpackage

// File: rtl/syncq_regs.sv
// syncq_regs: the two control registers.
// Assumes single-cycle writes. Reserved bits are masked on write, so they read 0.
// The one-shot self-clear of the divider-sync enable loses to a same-cycle write.
module syncq_regs
    import syncq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_addr,
    input  logic       self_clr,
    output logic [7:0] rd_data,
    output ctrl_t      ctrl,
    output pin_t       pin
);
    logic [7:0] ctrl_q;
    logic [7:0] pin_q;

    // Sync-control register: write first, then hardware self-clear of bit 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= 8'h00;
        else if (wr_en && wr_addr == ADDR_CTRL)
            ctrl_q <= wr_data & CTRL_MASK;
        else if (self_clr)
            ctrl_q <= ctrl_q & ~8'h02;
    end

    // Pin-control register: plain write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_q <= 8'h00;
        else if (wr_en && wr_addr == ADDR_PIN)
            pin_q <= wr_data & PIN_MASK;
    end

    // Read mux and typed views.
    always_comb begin
        rd_data = (rd_addr == ADDR_CTRL) ? ctrl_q : pin_q;
        ctrl    = ctrl_t'(ctrl_q[2:0]);
        pin     = pin_t'(pin_q[1:0]);
    end
endmodule

// File: rtl/syncq_detect.sv
// syncq_detect: a synchronizer chain followed by a level or edge detector.
// Assumes STAGES >= 2. Edges are found by comparing the synchronized value
// with its value one clock earlier.
module syncq_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic edge_mode,
    input  logic rise_sel,
    output logic hit
);
    logic [STAGES-1:0] chain;
    logic              prev;
    logic              s_now;

    // Shift the async input through the synchronizer and keep one history bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], sync_in};
            prev  <= chain[STAGES-1];
        end
    end

    // Select the high level, the rising edge or the falling edge.
    always_comb begin
        s_now = chain[STAGES-1];
        if (!edge_mode)
            hit = s_now;
        else if (rise_sel)
            hit = s_now & ~prev;
        else
            hit = ~s_now & prev;
    end
endmodule

// File: rtl/syncq_divider.sv
// syncq_divider: a divide-by-DIV_N counter with a synchronous realign input.
// Assumes DIV_N >= 1. On clear the count loads 0, so the output restarts a period.
module syncq_divider #(
    parameter int DIV_N = 5,
    localparam int CW   = (DIV_N > 1) ? $clog2(DIV_N) : 1,
    localparam int HALF = (DIV_N + 1) / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    output logic [CW-1:0] count,
    output logic          clk_out
);
    localparam logic [CW-1:0] LAST = CW'(DIV_N - 1);

    // Advance the phase, wrapping at DIV_N-1, or restart it on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            count <= '0;
        else if (count == LAST)
            count <= '0;
        else
            count <= count + 1'b1;
    end

    // High for the first half of each period.
    always_comb clk_out = ({1'b0, count} < (CW + 1)'(HALF));
endmodule

// File: rtl/syncq_top.sv
// syncq_top: qualifies the sync input and realigns the divider.
// Assumes sync_in is asynchronous and the register port is synchronous to clk.
module syncq_top
    import syncq_pkg::*;
#(
    parameter int DIV_N       = 5,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = (DIV_N > 1) ? $clog2(DIV_N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          rd_addr,
    output logic [7:0]    rd_data,
    input  logic          sync_in,
    output logic          div_out,
    output logic [CW-1:0] div_count
);
    ctrl_t ctrl;
    pin_t  pin;
    logic  hit;
    logic  div_rst;
    logic  self_clr;
    logic  master_en;
    logic  div_sync_en;
    logic  one_shot;

    syncq_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .self_clr(self_clr),
        .rd_data(rd_data), .ctrl(ctrl), .pin(pin)
    );

    syncq_detect #(.STAGES(SYNC_STAGES)) u_detect (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in),
        .edge_mode(pin.edge_mode), .rise_sel(pin.rise_sel), .hit(hit)
    );

    // Gate the detected event with both enables. One-shot requests the self-clear.
    always_comb begin
        master_en   = ctrl.master_en;
        div_sync_en = ctrl.div_sync_en;
        one_shot    = ctrl.one_shot;
        div_rst     = hit & master_en & div_sync_en;
        self_clr    = div_rst & one_shot;
    end

    syncq_divider #(.DIV_N(DIV_N)) u_div (
        .clk(clk), .rst_n(rst_n), .clear(div_rst),
        .count(div_count), .clk_out(div_out)
    );
endmodule

// File: rtl/syncq_checker.sv
// syncq_checker: temporal properties of syncq_top, attached with bind.
module syncq_checker #(
    parameter int DIV_N = 5,
    localparam int CW   = (DIV_N > 1) ? $clog2(DIV_N) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          wr_addr,
    input logic [7:0]    wr_data,
    input logic          rd_addr,
    input logic [7:0]    rd_data,
    input logic          master_en,
    input logic          div_sync_en,
    input logic          one_shot,
    input logic          div_rst,
    input logic [CW-1:0] div_count
);
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr ? rd_data[7:2] == 6'h0 : rd_data[7:3] == 5'h0));

    p_master_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |-> !div_rst);

    p_enable_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !div_sync_en |-> !div_rst);

    p_resync_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        div_rst |=> div_count == '0);

    p_self_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_rst && one_shot && !(wr_en && !wr_addr)) |=> !div_sync_en);

    p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr) |=> div_sync_en == $past(wr_data[1]));

    p_count_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_rst && div_count != CW'(DIV_N - 1)) |=> div_count == $past(div_count) + CW'(1));
endmodule

bind syncq_top syncq_checker #(.DIV_N(DIV_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .master_en(master_en), .div_sync_en(div_sync_en), .one_shot(one_shot),
    .div_rst(div_rst), .div_count(div_count)
);

// File: tb/test_syncq_top.sv
`timescale 1ns/1ps
module test_syncq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       sync_in = 1'b0;
    logic       div_out;
    logic [2:0] div_count;
    int n_chk = 0;
    int n_bad = 0;

    localparam int N = 5;

    syncq_top i_syncq_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sync_in(sync_in), .div_out(div_out), .div_count(div_count)
    );

    always #4 clk = ~clk;

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic a, input int exp, input string tag);
        @(negedge clk);
        rd_addr = a;
        #1 chk(int'(rd_data), exp, tag);
    endtask

    task automatic align();
        do @(negedge clk); while (div_count != 3'd0);
    endtask

    // Change sync_in at phase 0; three edges later: 0 if realigned, 3 if ignored.
    task automatic sync_try(input logic lvl, input logic exp_rs, input string tag);
        align();
        sync_in = lvl;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(int'(div_count), exp_rs ? 0 : 3, tag);
    endtask

    task automatic quiet();
        wr(1'b0, 8'h00);
        sync_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk(1'b0, 0, "R1 ctrl reset");
        rd_chk(1'b1, 0, "R1 pin reset");
        sync_try(1'b1, 1'b0, "R1 no sync after reset");
        sync_in = 1'b0;
        align();
        for (int i = 0; i < 2 * N; i++) begin
            chk(int'(div_count), i % N, "R11 count");
            chk(int'(div_out), (i % N) < (N + 1) / 2 ? 1 : 0, "R11 out");
            @(negedge clk);
        end
    endtask

    task automatic t_reserved();
        wr(1'b0, 8'hFF); rd_chk(1'b0, 8'h07, "R2 ctrl mask");
        wr(1'b1, 8'hFF); rd_chk(1'b1, 8'h03, "R2 pin mask");
        wr(1'b0, 8'h00); wr(1'b1, 8'h00);
    endtask

    task automatic t_gates();
        wr(1'b1, 8'h03);
        wr(1'b0, 8'h02);
        sync_try(1'b1, 1'b0, "R3 master off rise");
        sync_try(1'b0, 1'b0, "R3 master off fall");
        wr(1'b0, 8'h01);
        sync_try(1'b1, 1'b0, "R4 div enable off");
        quiet();
    endtask

    task automatic t_rising();
        wr(1'b1, 8'h03);
        wr(1'b0, 8'h03);
        sync_try(1'b1, 1'b1, "R9 rising accepted");
        sync_try(1'b0, 1'b0, "R9 falling ignored");
        sync_try(1'b1, 1'b1, "R5 second pulse realigns");
        quiet();
    endtask

    task automatic t_falling();
        wr(1'b1, 8'h02);
        wr(1'b0, 8'h03);
        sync_try(1'b1, 1'b0, "R10 rising ignored");
        sync_try(1'b0, 1'b1, "R10 falling accepted");
        sync_try(1'b1, 1'b0, "R10 rising ignored again");
        sync_try(1'b0, 1'b1, "R5 continuous falling again");
        quiet();
    endtask

    task automatic t_oneshot();
        wr(1'b1, 8'h03);
        wr(1'b0, 8'h07);
        rd_chk(1'b0, 8'h07, "R6 armed");
        sync_try(1'b1, 1'b1, "R6 first pulse");
        rd_chk(1'b0, 8'h05, "R6 self-cleared");
        sync_try(1'b0, 1'b0, "R6 fall ignored");
        sync_try(1'b1, 1'b0, "R6 later pulse ignored");
        quiet();
    endtask

    task automatic t_collide();
        wr(1'b1, 8'h03);
        wr(1'b0, 8'h07);
        align();
        sync_in = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h07;
        @(negedge clk);
        wr_en = 1'b0;
        chk(int'(div_count), 0, "R7 pulse taken");
        rd_chk(1'b0, 8'h07, "R7 write wins");
        sync_try(1'b0, 1'b0, "R7 fall ignored");
        sync_try(1'b1, 1'b1, "R7 next pulse accepted");
        quiet();
    endtask

    task automatic t_level();
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h03);
        sync_try(1'b1, 1'b1, "R8 level high");
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(int'(div_count), 0, "R8 held");
        end
        sync_in = 1'b0;
        repeat (3) @(negedge clk);
        chk(int'(div_count), 1, "R8 released");
        @(negedge clk);
        chk(int'(div_count), 2, "R8 counting");
        quiet();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reserved();
        t_gates();
        t_rising();
        t_falling();
        t_oneshot();
        t_collide();
        t_level();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule